// File: doc/BRIEF.md
# Burst Write Receiver with Slot Buffer

The receiver takes write transfers from a 16-bit beat channel and files them into an eight-item buffer. Each item holds sixteen 16-bit words (32 bytes), a 16-bit mask and an upper-half tag. A transfer opens with one header beat, qualified by `wr_valid`. The header flags decide whether a mask beat comes before the data and whether the transfer fills one item or two. Every beat after the header arrives with `wr_valid` low, one beat per cycle. A strobe seen in the middle of a transfer is a protocol error, and that beat is dropped.

The block always advertises the lowest-numbered free item on `free_slot`. It shows the code 8 when no item is free. This value is refreshed in the cycle after each item finishes filling and in the cycle after a release. Items are returned by pulsing `rel_valid` with an item index. A combinational read port lets the consumer fetch a stored word, the item's mask and its upper tag.

The controller is a three-state machine with states IDLE, MASK and DATA.
- IDLE to MASK: an accepted header with the mask flag set.
- IDLE to DATA: an accepted header with the mask flag clear.
- MASK to DATA: the mask beat has been stored.
- DATA to DATA: an ordinary data beat. Also the sixteenth beat of the lower half of a two-item transfer when no mask beat is expected.
- DATA to MASK: the sixteenth beat of the lower half of a two-item transfer when a mask beat is expected.
- DATA to IDLE: the final data beat of the operation.
- Rejected headers keep the machine in IDLE. A mid-transfer strobe keeps it in MASK or DATA.

Top module: `burst_wr_rx`

## Requirements
- R1: After reset, `free_slot` is 0, `free_valid` is 1, and both `done` and `proto_err` are 0.
- R2: A header is a `wr_valid` beat accepted in IDLE. Header bit 0 means a mask beat follows, bit 1 means a 64-byte (two-item) transfer, and bit 2 is the upper tag. Bits 15:3 are ignored.
- R3: A mask beat is stored as the mask of the item being filled. An item filled without a mask beat reads back mask 16'hFFFF.
- R4: Data beats are counted from 0 to 15, and beat k is stored as word k of the item. A one-item transfer fills the lowest free item seen at the header.
- R5: A 64-byte transfer fills the lowest free item and then the next free item above it. Each half has its own mask beat when bit 0 is set. Header bit 2 is ignored here: the first item's tag reads 0 and the second item's tag reads 1. In a one-item transfer, the tag equals header bit 2.
- R6: In the cycle after the sixteenth data beat of an item, that item is occupied. `free_slot` then shows the lowest free index, or 8 when none is free.
- R7: In the cycle after a release (`rel_valid` with `rel_slot`), that item is free and `free_slot` shows the lowest free index. Releasing an item that is already free has no effect.
- R8: `done` is high for exactly one cycle: the cycle after the final data beat of an operation.
- R9: `proto_err` is high for one cycle after any of three events, and the offending beat is dropped. The first is a strobe during a transfer. The second is a header while `free_valid` is 0. The third is a 64-byte header when fewer than two items are free.
- R10: `free_valid` is 1 only in IDLE with at least one free item. It is 0 while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Header strobe |
| wr_data | input | 16 | Header, mask or data beat |
| rel_valid | input | 1 | Release request |
| rel_slot | input | 3 | Item to release |
| rd_slot | input | 3 | Read item index |
| rd_beat | input | 4 | Read word index |
| free_slot | output | 4 | Lowest free item, 8 when full |
| free_valid | output | 1 | A new header may be sent |
| done | output | 1 | Operation finished (one-cycle pulse) |
| proto_err | output | 1 | Dropped beat (one-cycle pulse) |
| rd_data | output | 16 | Stored word |
| rd_mask | output | 16 | Item mask |
| rd_upper | output | 1 | Item upper tag |

## Verification
Transfers are sent with all eight combinations of the three header flags and random reserved bits. This separates the one-item and two-item lengths, the paths with and without a mask beat, and how the upper tag is handled. Interleaved releases in random order make the allocation pick holes that are not the lowest index, which exposes any error in the lowest-free or next-free search. Directed cases fill the buffer completely and send a 64-byte header when only one item is free. They also inject a strobe part-way through the data beats, and the read-back confirms that the dropped word never reached storage.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MASK = 2'd1,
        ST_DATA = 2'd2
    } bwr_state_e;

    localparam int HDR_MASK_BIT  = 0;
    localparam int HDR_WIDE_BIT  = 1;
    localparam int HDR_UPPER_BIT = 2;
endpackage

// File: rtl/bwr_slot_alloc.sv
module bwr_slot_alloc #(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = $clog2(SLOTS),
    parameter int FREE_W = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_v,
    input  logic [SLOT_W-1:0] set_slot,
    input  logic              rel_v,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic [FREE_W-1:0] free_slot,
    output logic [SLOT_W-1:0] low_slot,
    output logic [SLOT_W-1:0] next_slot,
    output logic              two_free
);
    localparam logic [FREE_W-1:0] FULL_CODE = FREE_W'(SLOTS);

    logic [SLOTS-1:0] occ, occ_n, occ_hide;
    logic [FREE_W-1:0] low_idx, next_idx;

    function automatic logic [FREE_W-1:0] first_zero(input logic [SLOTS-1:0] v);
        logic [FREE_W-1:0] r;
        r = FULL_CODE;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!v[i]) r = FREE_W'(i);
        end
        return r;
    endfunction

    always_comb begin
        occ_n = occ;
        if (rel_v) occ_n[rel_slot] = 1'b0;
        if (set_v) occ_n[set_slot] = 1'b1;
    end

    always_comb begin
        low_idx  = first_zero(occ);
        occ_hide = occ;
        if (low_idx != FULL_CODE) occ_hide[low_idx[SLOT_W-1:0]] = 1'b1;
        next_idx = first_zero(occ_hide);
    end

    assign low_slot  = low_idx[SLOT_W-1:0];
    assign next_slot = next_idx[SLOT_W-1:0];
    assign two_free  = (next_idx != FULL_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ       <= '0;
            free_slot <= '0;
        end else begin
            occ       <= occ_n;
            free_slot <= first_zero(occ_n);
        end
    end

    AST_FULL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (free_slot == FULL_CODE) |-> (&occ));  // R6
    AST_FREE_IS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (free_slot != FULL_CODE) |-> !occ[free_slot[SLOT_W-1:0]]);  // R6
    AST_REL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_v && !(set_v && set_slot == rel_slot)) |=> !occ[$past(rel_slot)]);  // R7
endmodule

// File: rtl/bwr_slot_store.sv
module bwr_slot_store #(
    parameter int SLOTS  = 8,
    parameter int BEATS  = 16,
    parameter int DATA_W = 16,
    parameter int SLOT_W = $clog2(SLOTS),
    parameter int IDX_W  = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic [SLOT_W-1:0] data_slot,
    input  logic [IDX_W-1:0]  data_idx,
    input  logic [DATA_W-1:0] data_val,
    input  logic              init_we,
    input  logic [SLOT_W-1:0] init_slot,
    input  logic              init_upper,
    input  logic              mask_we,
    input  logic [SLOT_W-1:0] mask_slot,
    input  logic [DATA_W-1:0] mask_val,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] rd_mask,
    output logic              rd_upper
);
    logic [DATA_W-1:0] words [SLOTS][BEATS];
    logic [DATA_W-1:0] masks [SLOTS];
    logic [SLOTS-1:0]  uppers;

    always_ff @(posedge clk) begin
        if (data_we) words[data_slot][data_idx] <= data_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) masks[s] <= '1;
            uppers <= '0;
        end else begin
            if (init_we) begin
                masks[init_slot]  <= '1;
                uppers[init_slot] <= init_upper;
            end
            if (mask_we) masks[mask_slot] <= mask_val;
        end
    end

    assign rd_data  = words[rd_slot][rd_idx];
    assign rd_mask  = masks[rd_slot];
    assign rd_upper = uppers[rd_slot];

    AST_NO_DUAL_META: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_we && mask_we));  // R3
endmodule

// File: rtl/burst_wr_rx.sv
module burst_wr_rx
    import bwr_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int BEATS  = 16,
    parameter int DATA_W = 16,
    parameter int SLOT_W = $clog2(SLOTS),
    parameter int FREE_W = $clog2(SLOTS + 1),
    parameter int IDX_W  = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rel_valid,
    input  logic [SLOT_W-1:0] rel_slot,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [IDX_W-1:0]  rd_beat,
    output logic [FREE_W-1:0] free_slot,
    output logic              free_valid,
    output logic              done,
    output logic              proto_err,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] rd_mask,
    output logic              rd_upper
);
    localparam logic [FREE_W-1:0] FULL_CODE = FREE_W'(SLOTS);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(BEATS - 1);

    bwr_state_e        st, st_n;
    logic              half, half_n, f_mask, f_mask_n, f_wide, f_wide_n;
    logic [IDX_W-1:0]  cnt, cnt_n;
    logic [SLOT_W-1:0] slot_a, slot_a_n, slot_b, slot_b_n, cur_slot;
    logic              done_n, err_n;
    logic              data_we, init_we, init_upper, mask_we, set_v;
    logic [SLOT_W-1:0] init_slot, low_slot, next_slot;
    logic              two_free;

    assign cur_slot   = half ? slot_b : slot_a;
    assign free_valid = (st == ST_IDLE) && (free_slot != FULL_CODE);

    bwr_slot_alloc #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .FREE_W(FREE_W)) u_alloc (
        .clk(clk), .rst_n(rst_n),
        .set_v(set_v), .set_slot(cur_slot),
        .rel_v(rel_valid), .rel_slot(rel_slot),
        .free_slot(free_slot), .low_slot(low_slot),
        .next_slot(next_slot), .two_free(two_free)
    );

    bwr_slot_store #(.SLOTS(SLOTS), .BEATS(BEATS), .DATA_W(DATA_W),
                     .SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .data_we(data_we), .data_slot(cur_slot), .data_idx(cnt), .data_val(wr_data),
        .init_we(init_we), .init_slot(init_slot), .init_upper(init_upper),
        .mask_we(mask_we), .mask_slot(cur_slot), .mask_val(wr_data),
        .rd_slot(rd_slot), .rd_idx(rd_beat),
        .rd_data(rd_data), .rd_mask(rd_mask), .rd_upper(rd_upper)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            half      <= 1'b0;
            f_mask    <= 1'b0;
            f_wide    <= 1'b0;
            cnt       <= '0;
            slot_a    <= '0;
            slot_b    <= '0;
            done      <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            st        <= st_n;
            half      <= half_n;
            f_mask    <= f_mask_n;
            f_wide    <= f_wide_n;
            cnt       <= cnt_n;
            slot_a    <= slot_a_n;
            slot_b    <= slot_b_n;
            done      <= done_n;
            proto_err <= err_n;
        end
    end

    always_comb begin
        st_n       = st;
        half_n     = half;
        f_mask_n   = f_mask;
        f_wide_n   = f_wide;
        cnt_n      = cnt;
        slot_a_n   = slot_a;
        slot_b_n   = slot_b;
        done_n     = 1'b0;
        err_n      = 1'b0;
        data_we    = 1'b0;
        init_we    = 1'b0;
        init_slot  = slot_a;
        init_upper = 1'b0;
        mask_we    = 1'b0;
        set_v      = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (wr_valid) begin
                    if (!free_valid || (wr_data[HDR_WIDE_BIT] && !two_free)) begin
                        err_n = 1'b1;
                    end else begin
                        f_mask_n   = wr_data[HDR_MASK_BIT];
                        f_wide_n   = wr_data[HDR_WIDE_BIT];
                        slot_a_n   = low_slot;
                        slot_b_n   = next_slot;
                        half_n     = 1'b0;
                        cnt_n      = '0;
                        init_we    = 1'b1;
                        init_slot  = low_slot;
                        init_upper = wr_data[HDR_WIDE_BIT] ? 1'b0 : wr_data[HDR_UPPER_BIT];
                        st_n       = wr_data[HDR_MASK_BIT] ? ST_MASK : ST_DATA;
                    end
                end
            end
            ST_MASK: begin
                if (wr_valid) begin
                    err_n = 1'b1;
                end else begin
                    mask_we = 1'b1;
                    st_n    = ST_DATA;
                end
            end
            ST_DATA: begin
                if (wr_valid) begin
                    err_n = 1'b1;
                end else begin
                    data_we = 1'b1;
                    cnt_n   = cnt + 1'b1;
                    if (cnt == LAST_IDX) begin
                        set_v = 1'b1;
                        cnt_n = '0;
                        if (f_wide && !half) begin
                            half_n     = 1'b1;
                            init_we    = 1'b1;
                            init_slot  = slot_b;
                            init_upper = 1'b1;
                            st_n       = f_mask ? ST_MASK : ST_DATA;
                        end else begin
                            done_n = 1'b1;
                            st_n   = ST_IDLE;
                        end
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    AST_HDR_REJECT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && wr_valid && free_slot == FULL_CODE) |=> (proto_err && st == ST_IDLE));  // R9
    AST_MID_STROBE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && wr_valid) |=> (proto_err && cnt == $past(cnt) && st == $past(st)));  // R9
    AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (st == ST_IDLE));  // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> !free_valid);  // R10
endmodule

// File: tb/burst_wr_rx_tb.sv
module burst_wr_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rel_valid = 1'b0;
    logic [2:0]  rel_slot = '0;
    logic [2:0]  rd_slot = '0;
    logic [3:0]  rd_beat = '0;
    logic [3:0]  free_slot;
    logic        free_valid, done, proto_err, rd_upper;
    logic [15:0] rd_data, rd_mask;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    bit [7:0]    occ_m = '0;
    logic [15:0] mem_m [8][16];
    logic [15:0] mask_m [8];
    bit          up_m [8];

    always #2 clk = ~clk;

    burst_wr_rx u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rel_valid(rel_valid), .rel_slot(rel_slot), .rd_slot(rd_slot), .rd_beat(rd_beat),
        .free_slot(free_slot), .free_valid(free_valid), .done(done), .proto_err(proto_err),
        .rd_data(rd_data), .rd_mask(rd_mask), .rd_upper(rd_upper)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int low_free(input int skip);
        for (int i = 0; i < 8; i++) if (!occ_m[i] && i != skip) return i;
        return 8;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic readback(input int s);
        rd_slot = 3'(s);
        @(negedge clk);
        chk("R3 mask readback", int'(rd_mask), int'(mask_m[s]));
        chk("R5 upper tag", int'(rd_upper), int'(up_m[s]));
        for (int k = 0; k < 16; k += 5) begin
            rd_beat = 4'(k);
            @(negedge clk);
            chk("R4 word readback", int'(rd_data), int'(mem_m[s][k]));
        end
        rd_beat = 4'd15;
        @(negedge clk);
        chk("R4 last word readback", int'(rd_data), int'(mem_m[s][15]));
        step();
    endtask

    task automatic transfer(input bit mk, input bit wide, input bit up, input bit inject);
        int a, b, slot;
        bit ok;
        logic [15:0] v;
        a  = low_free(-1);
        b  = (a == 8) ? 8 : low_free(a);
        ok = (a != 8) && (!wide || b != 8);
        wr_valid = 1'b1;
        wr_data  = {13'($urandom), up, wide, mk};
        step();
        wr_valid = 1'b0;
        if (!ok) begin
            chk("R9 header rejected", int'(proto_err), 1);
            chk("R9 rejected header keeps free_slot", int'(free_slot), a);
            step();
            chk("R9 error is one pulse", int'(proto_err), 0);
            return;
        end
        chk("R10 busy clears free_valid", int'(free_valid), 0);
        for (int h = 0; h <= int'(wide); h++) begin
            slot = (h == 1) ? b : a;
            up_m[slot]   = wide ? bit'(h) : up;
            mask_m[slot] = 16'hFFFF;
            if (mk) begin
                v = 16'($urandom);
                wr_data = v;
                mask_m[slot] = v;
                step();
            end
            for (int i = 0; i < 16; i++) begin
                if (inject && h == 0 && i == 7) begin
                    wr_valid = 1'b1;
                    wr_data  = 16'hDEAD;
                    step();
                    chk("R9 mid-transfer strobe", int'(proto_err), 1);
                    wr_valid = 1'b0;
                end
                v = 16'($urandom);
                wr_data = v;
                mem_m[slot][i] = v;
                step();
                if (i == 15) begin
                    occ_m[slot] = 1'b1;
                    chk("R6 free_slot after item", int'(free_slot), low_free(-1));
                    chk("R8 done pulse", int'(done), (h == int'(wide)) ? 1 : 0);
                end
            end
        end
        step();
        chk("R8 done drops", int'(done), 0);
        chk("R10 free_valid after op", int'(free_valid), (low_free(-1) != 8) ? 1 : 0);
        readback(a);
        if (wide) readback(b);
    endtask

    task automatic release_slot(input int s);
        rel_valid = 1'b1;
        rel_slot  = 3'(s);
        step();
        rel_valid = 1'b0;
        occ_m[s]  = 1'b0;
        chk("R7 free_slot after release", int'(free_slot), low_free(-1));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < 8; s++) begin
            mask_m[s] = 16'hFFFF;
            up_m[s]   = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        chk("R1 reset free_slot", int'(free_slot), 0);
        chk("R1 reset free_valid", int'(free_valid), 1);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset proto_err", int'(proto_err), 0);

        // R5 fill every item with two-item transfers, mask beats and tag bit set
        for (int t = 0; t < 4; t++) transfer(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R6 full code", int'(free_slot), 8);
        chk("R10 full clears free_valid", int'(free_valid), 0);
        transfer(1'b0, 1'b0, 1'b0, 1'b0);             // R9 header when full
        release_slot(3);
        transfer(1'b0, 1'b0, 1'b1, 1'b0);             // R2 one item into slot 3, tag 1
        release_slot(5);
        transfer(1'b1, 1'b1, 1'b0, 1'b0);             // R9 wide with one free item
        release_slot(0);
        transfer(1'b0, 1'b1, 1'b1, 1'b1);             // R5 items 0 and 5, mid strobe
        release_slot(2);
        release_slot(2);                              // R7 release of a free item
        chk("R7 repeated release", int'(free_slot), 2);
        release_slot(6);
        transfer(1'b1, 1'b0, 1'b0, 1'b1);             // R3 R4 one item with mask

        for (int it = 0; it < 80; it++) begin
            int r;
            r = int'($urandom % 3);
            if (r == 0) release_slot(int'($urandom % 8));
            else transfer(bit'($urandom), bit'($urandom), bit'($urandom), ($urandom % 4) == 0);
        end
        finish_run();
    end
endmodule